// File: doc/BRIEF.md
# Rate-Steering Sample Buffer with Oscillator Retune

The block sits between a digital audio receiver and the converters. Samples arrive with a valid strobe in the receiver clock domain. They are written into a dual-clock FIFO and leave it unchanged on a locally generated master clock that runs at 256 times the sample rate. A one-cycle read request marks each sample period. The local clock comes from a voltage-controlled crystal oscillator. The block tunes that oscillator by sending a 16-bit code to a serial control DAC.

The rate is not tracked continuously. A three-state controller waits for the FIFO to fill up to the high bound and then raises the oscillator code by a fixed step, so the buffer drains slowly. When the fill level falls to the low bound, the controller lowers the code by the same step below nominal, so the buffer refills. The cycle then repeats. Corrections therefore come rarely, and each one is a single small step. The two bounds and the step size are runtime inputs. A family select input chooses between the nominal codes for the 44.1 kHz and 48 kHz clock families.

After reset the read side outputs silence until the buffer is half full. Two sticky flags record an underflow or an overflow.

Top module: `fifo_vcxo_ctrl`

## Requirements
- R1: Every sample accepted on the write side appears on `rd_sample` unchanged and in arrival order. A sample is accepted when `wr_valid` is high and the FIFO (depth 2^AW, 16 by default) is not full. Each sample is presented one `rd_clk` cycle after the read request that takes it.
- R2: `playing` is low after reset. It rises when the read-side level reaches floor((bound_lo+bound_hi)/2) and then stays high until reset. While `playing` is low, a read request returns zero and removes nothing from the FIFO.
- R3: A write while the FIFO holds 2^AW samples is dropped, and `overflow` is set. `overflow` stays set until `wr_rst_n` is asserted.
- R4: A read request while playing and with the FIFO empty returns zero and sets `underflow`. `underflow` stays set until `rd_rst_n` is asserted.
- R5: Reset puts the controller in state FILLING, and `ctrl_code` then equals the nominal code of the selected family. The defaults are 0x8000 when `family_sel`=0 and 0x7000 when `family_sel`=1.
- R6: From FILLING or FILL_TO_HIGH, a level at or above `bound_hi` moves the controller to DRAIN_TO_LOW. In DRAIN_TO_LOW the code is nominal plus `step`.
- R7: From DRAIN_TO_LOW, a level at or below `bound_lo` moves the controller to FILL_TO_HIGH. In FILL_TO_HIGH the code is nominal minus `step`. No other transition exists, so a bound crossing in the direction already being steered changes nothing.
- R8: The code saturates. Nominal plus step clips to 0xFFFF, and nominal minus step clips to 0x0000.
- R9: `ctrl_code` follows changes of `family_sel` and `step` at once, in every state.
- R10: A serial frame holds `spi_cs_n` low for 24 rising edges of `spi_sclk`. The frame carries the 8-bit command 0x30 and then the 16-bit code, MSB first. `spi_sclk` runs at half the `rd_clk` rate and idles low. `spi_mosi` changes only while `spi_sclk` is low.
- R11: A frame is sent after reset, and again whenever `ctrl_code` differs from the last code sent. A frame never starts while another is in progress. When a frame ends, the newest code is sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receiver-domain clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Sample strobe |
| wr_data | input | DW | Incoming sample |
| rd_clk | input | 1 | Local master clock (256fs) |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_req | input | 1 | One-cycle request for the next sample |
| family_sel | input | 1 | Clock family: 0 = 44.1 kHz, 1 = 48 kHz |
| bound_lo | input | AW+1 | Low occupancy bound |
| bound_hi | input | AW+1 | High occupancy bound |
| step | input | 16 | Code offset applied around nominal |
| rd_sample | output | DW | Sample out, zero when silent |
| playing | output | 1 | Read side has started output |
| underflow | output | 1 | Sticky empty-read flag |
| overflow | output | 1 | Sticky full-write flag (write domain) |
| ctrl_code | output | 16 | Current oscillator code |
| spi_sclk | output | 1 | Serial clock to the control DAC |
| spi_cs_n | output | 1 | Serial frame select, active low |
| spi_mosi | output | 1 | Serial data to the control DAC |

## Verification
Two events can land in the same cycle. The first pair is a code change and a serial frame that is still being sent. The bench switches `family_sel` a few cycles after the frame carrying the bound-crossing code has begun. It then requires that frame to finish intact and the new code to go out in the very next frame. The second pair is a write and a read hitting the FIFO together. Writes and reads run concurrently while the level sits near the low bound. The scoreboard checks that every sample still arrives in order and that no retune frame is produced.

// File: rtl/fvc_pkg.sv
package fvc_pkg;
    typedef enum logic [1:0] {
        FILLING      = 2'd0,
        DRAIN_TO_LOW = 2'd1,
        FILL_TO_HIGH = 2'd2
    } ctl_state_t;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_t;
endpackage

// File: rtl/fvc_sync2.sv
module fvc_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fvc_cdc_fifo.sv
module fvc_cdc_fifo #(
    parameter int DW = 24,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_push,
    input  logic [DW-1:0] wr_din,
    output logic          wr_ovf,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_dout,
    output logic [AW:0]   rd_level
);
    localparam int DEPTH = 1 << AW;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] from_gray(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];

    // write domain
    logic [AW:0] wbin, wgray, rgray_w, rbin_w, used_w;
    logic        wr_full;

    fvc_sync2 #(.W(AW+1)) u_rsync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w)
    );

    assign rbin_w  = from_gray(rgray_w);
    assign used_w  = wbin - rbin_w;
    assign wr_full = used_w[AW];

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            wr_ovf <= 1'b0;
        end else if (wr_push) begin
            if (wr_full) begin
                wr_ovf <= 1'b1;
            end else begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_push && !wr_full) begin
            mem[wbin[AW-1:0]] <= wr_din;
        end
    end

    // read domain
    logic [AW:0] rbin, rgray, wgray_r, wbin_r;

    fvc_sync2 #(.W(AW+1)) u_wsync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r)
    );

    assign wbin_r   = from_gray(wgray_r);
    assign rd_level = wbin_r - rbin;
    assign rd_dout  = mem[rbin[AW-1:0]];

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_pop && (rd_level != '0)) begin
            rbin  <= rbin + 1'b1;
            rgray <= to_gray(rbin + 1'b1);
        end
    end
endmodule

// File: rtl/fvc_level_ctrl.sv
module fvc_level_ctrl
    import fvc_pkg::*;
#(
    parameter int          AW    = 4,
    parameter logic [15:0] NOM_A = 16'h8000,
    parameter logic [15:0] NOM_B = 16'h7000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] level,
    input  logic [AW:0] bound_lo,
    input  logic [AW:0] bound_hi,
    input  logic [15:0] step,
    input  logic        family_sel,
    output ctl_state_t  state,
    output logic [15:0] code
);
    ctl_state_t  state_nx;
    logic [15:0] nominal;
    logic [16:0] up_sum;

    always_comb begin
        state_nx = state;
        unique case (state)
            FILLING:      if (level >= bound_hi) state_nx = DRAIN_TO_LOW;
            DRAIN_TO_LOW: if (level <= bound_lo) state_nx = FILL_TO_HIGH;
            FILL_TO_HIGH: if (level >= bound_hi) state_nx = DRAIN_TO_LOW;
            default:      state_nx = FILLING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FILLING;
        else        state <= state_nx;
    end

    assign nominal = family_sel ? NOM_B : NOM_A;
    assign up_sum  = {1'b0, nominal} + {1'b0, step};

    always_comb begin
        unique case (state)
            DRAIN_TO_LOW: code = up_sum[16] ? 16'hFFFF : up_sum[15:0];
            FILL_TO_HIGH: code = (nominal < step) ? 16'h0000 : (nominal - step);
            default:      code = nominal;
        endcase
    end
endmodule

// File: rtl/fvc_dac_spi.sv
module fvc_dac_spi
    import fvc_pkg::*;
#(
    parameter logic [7:0] CMD = 8'h30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] code,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi
);
    localparam int FRAME = 24;
    localparam int CW    = $clog2(FRAME);

    tx_state_t         state;
    logic [FRAME-1:0]  shreg;
    logic [CW-1:0]     bitcnt;
    logic              phase;
    logic [15:0]       sent_code;
    logic              sent_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            phase     <= 1'b0;
            sent_code <= '0;
            sent_ok   <= 1'b0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (!sent_ok || (code != sent_code)) begin
                        state     <= TX_SHIFT;
                        shreg     <= {CMD, code};
                        sent_code <= code;
                        sent_ok   <= 1'b1;
                        bitcnt    <= '0;
                        phase     <= 1'b0;
                    end
                end
                TX_SHIFT: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        if (bitcnt == CW'(FRAME - 1)) begin
                            state <= TX_IDLE;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            shreg  <= {shreg[FRAME-2:0], 1'b0};
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_n = (state == TX_IDLE);
        sclk = (state == TX_SHIFT) && phase;
        mosi = (state == TX_SHIFT) ? shreg[FRAME-1] : 1'b0;
    end
endmodule

// File: rtl/fifo_vcxo_ctrl.sv
module fifo_vcxo_ctrl
    import fvc_pkg::*;
#(
    parameter int          DW    = 24,
    parameter int          AW    = 4,
    parameter logic [15:0] NOM_A = 16'h8000,
    parameter logic [15:0] NOM_B = 16'h7000,
    parameter logic [7:0]  CMD   = 8'h30
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_req,
    input  logic          family_sel,
    input  logic [AW:0]   bound_lo,
    input  logic [AW:0]   bound_hi,
    input  logic [15:0]   step,
    output logic [DW-1:0] rd_sample,
    output logic          playing,
    output logic          underflow,
    output logic          overflow,
    output logic [15:0]   ctrl_code,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi
);
    logic [DW-1:0] fifo_dout;
    logic [AW:0]   rd_level;
    logic [AW+1:0] bound_sum;
    logic [AW:0]   mid_level;
    logic          pop;
    ctl_state_t    ctl_state;

    assign bound_sum = {1'b0, bound_lo} + {1'b0, bound_hi};
    assign mid_level = bound_sum[AW+1:1];
    assign pop       = rd_req && playing;

    fvc_cdc_fifo #(.DW(DW), .AW(AW)) u_fifo (
        .wr_clk  (wr_clk),
        .wr_rst_n(wr_rst_n),
        .wr_push (wr_valid),
        .wr_din  (wr_data),
        .wr_ovf  (overflow),
        .rd_clk  (rd_clk),
        .rd_rst_n(rd_rst_n),
        .rd_pop  (pop),
        .rd_dout (fifo_dout),
        .rd_level(rd_level)
    );

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            playing   <= 1'b0;
            underflow <= 1'b0;
            rd_sample <= '0;
        end else begin
            if (!playing && (rd_level >= mid_level)) playing <= 1'b1;
            if (rd_req) begin
                if (!playing) begin
                    rd_sample <= '0;
                end else if (rd_level == '0) begin
                    rd_sample <= '0;
                    underflow <= 1'b1;
                end else begin
                    rd_sample <= fifo_dout;
                end
            end
        end
    end

    fvc_level_ctrl #(.AW(AW), .NOM_A(NOM_A), .NOM_B(NOM_B)) u_ctrl (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .level     (rd_level),
        .bound_lo  (bound_lo),
        .bound_hi  (bound_hi),
        .step      (step),
        .family_sel(family_sel),
        .state     (ctl_state),
        .code      (ctrl_code)
    );

    fvc_dac_spi #(.CMD(CMD)) u_spi (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .code (ctrl_code),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi)
    );
endmodule

// File: rtl/fvc_checker.sv
module fvc_checker
    import fvc_pkg::*;
#(
    parameter int DW = 24,
    parameter int AW = 4
) (
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          playing,
    input logic          underflow,
    input logic          overflow,
    input logic [DW-1:0] rd_sample,
    input logic          spi_sclk,
    input logic          spi_cs_n,
    input logic          spi_mosi,
    input ctl_state_t    ctl_state,
    input logic [AW:0]   rd_level,
    input logic [AW:0]   bound_lo
);
    // R2: silence before playback starts
    assert_silent_before_play_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !playing |=> (rd_sample == '0));

    // R2: playback never stops once started
    assert_play_sticky_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        playing |=> playing);

    // R3: overflow flag is sticky
    assert_ovf_sticky_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    // R4: underflow flag is sticky
    assert_unf_sticky_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        underflow |=> underflow);

    // R7: draining continues until the low bound is reached
    assert_drain_holds_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (ctl_state == DRAIN_TO_LOW && rd_level > bound_lo) |=> (ctl_state == DRAIN_TO_LOW));

    // R10: data steady while the serial clock is high
    assert_mosi_stable_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        spi_sclk |-> $stable(spi_mosi));

    // R10: frame begins with the serial clock low
    assert_frame_start_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);
endmodule

bind fifo_vcxo_ctrl fvc_checker #(.DW(DW), .AW(AW)) u_chk (
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .playing  (playing),
    .underflow(underflow),
    .overflow (overflow),
    .rd_sample(rd_sample),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .ctl_state(ctl_state),
    .rd_level (rd_level),
    .bound_lo (bound_lo)
);

// File: tb/fifo_vcxo_ctrl_test.sv
module fifo_vcxo_ctrl_test;
    localparam int DW = 24;
    localparam int AW = 4;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_valid = 0, rd_req = 0, family_sel = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0]   bound_lo = 5'd4, bound_hi = 5'd12;
    logic [15:0]   step = 16'h0100;
    logic [DW-1:0] rd_sample;
    logic          playing, underflow, overflow, spi_sclk, spi_cs_n, spi_mosi;
    logic [15:0]   ctrl_code;

    fifo_vcxo_ctrl #(.DW(DW), .AW(AW)) uut (.*);

    always #10 rd_clk = ~rd_clk;   // 50 MHz
    always #13 wr_clk = ~wr_clk;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] data_q[$];
    logic [DW-1:0] exp_rd_q[$];
    logic [15:0]   exp_frames[$];
    logic [DW-1:0] seq = 24'h5A0000;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_one(input bit keep);
        @(negedge wr_clk);
        wr_valid = 1; wr_data = seq;
        if (keep) data_q.push_back(seq);
        seq = seq + 24'h010203;
        @(negedge wr_clk);
        wr_valid = 0;
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) wr_one(1);
    endtask

    task automatic rd_one(input bit silent);
        @(negedge rd_clk);
        rd_req = 1;
        if (silent || data_q.size() == 0) exp_rd_q.push_back('0);
        else exp_rd_q.push_back(data_q.pop_front());
        @(negedge rd_clk);
        rd_req = 0;
    endtask

    task automatic rd_n(input int n);
        for (int i = 0; i < n; i++) rd_one(0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // sample monitor (R1, R2, R4)
    logic req_d = 0;
    always @(posedge rd_clk) req_d <= rd_req;
    always @(negedge rd_clk) begin
        if (req_d) begin
            if (exp_rd_q.size() == 0) check("R1 unexpected sample", 32'(rd_sample), 32'hDEAD);
            else check("R1 sample order/value", 32'(rd_sample), 32'(exp_rd_q.pop_front()));
        end
    end

    // serial frame monitor (R10, R11)
    logic [23:0] rx_word = '0;
    int          rx_bits = 0;
    always @(negedge spi_cs_n) begin rx_word = '0; rx_bits = 0; end
    always @(posedge spi_sclk) if (!spi_cs_n) begin rx_word = {rx_word[22:0], spi_mosi}; rx_bits++; end
    always @(posedge spi_cs_n) if (rd_rst_n) begin
        check("R10 frame length", 32'(rx_bits), 32'd24);
        if (exp_frames.size() == 0) check("R11 unexpected frame", 32'(rx_word), 32'hDEAD);
        else check("R10 R11 frame content", 32'(rx_word), {8'h0, 8'h30, exp_frames.pop_front()});
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        exp_frames.push_back(16'h8000);
        idle(5);
        check("R5 reset code", 32'(ctrl_code), 32'h8000);
        check("R10 cs idle", 32'(spi_cs_n), 1);
        check("R10 sclk idle", 32'(spi_sclk), 0);
        check("R2 playing reset", 32'(playing), 0);
        check("R2 sample reset", 32'(rd_sample), 0);
        check("R4 underflow reset", 32'(underflow), 0);
        check("R3 overflow reset", 32'(overflow), 0);
        wr_rst_n = 1; rd_rst_n = 1;
        idle(80);

        wr_n(7); idle(10);
        check("R2 not playing below mid", 32'(playing), 0);
        rd_one(1); rd_one(1); idle(4);         // ignored: nothing popped
        check("R4 no underflow while silent", 32'(underflow), 0);
        wr_n(1); idle(10);
        check("R2 playing at mid", 32'(playing), 1);
        check("R5 still nominal", 32'(ctrl_code), 32'h8000);

        exp_frames.push_back(16'h8100);
        wr_n(4);
        @(negedge spi_cs_n); idle(4);
        check("R6 drain code", 32'(ctrl_code), 32'h8100);
        exp_frames.push_back(16'h7100);        // change during frame in flight
        family_sel = 1; idle(1);
        check("R9 family change", 32'(ctrl_code), 32'h7100);
        idle(120);

        exp_frames.push_back(16'hFFFF);
        step = 16'hF000; idle(1);
        check("R8 R9 high clip", 32'(ctrl_code), 32'hFFFF);
        idle(120);

        exp_frames.push_back(16'h0000);
        rd_n(8); idle(5);
        check("R7 R8 fill code low clip", 32'(ctrl_code), 32'h0000);
        idle(120);

        fork
            wr_n(10);
            for (int i = 0; i < 10; i++) begin rd_one(0); idle(1); end
        join
        idle(10);
        check("R7 no retune on concurrent traffic", 32'(ctrl_code), 32'h0000);

        exp_frames.push_back(16'hFFFF);
        wr_n(8); idle(10);
        check("R6 drain again", 32'(ctrl_code), 32'hFFFF);
        idle(120);
        exp_frames.push_back(16'h0000);
        rd_n(12); idle(5);
        check("R4 no underflow yet", 32'(underflow), 0);
        rd_one(0); idle(3);
        check("R4 underflow set", 32'(underflow), 1);
        idle(120);

        exp_frames.push_back(16'hFFFF);
        exp_frames.push_back(16'h0000);
        for (int i = 0; i < 16; i++) wr_one(1);
        idle(5);
        check("R3 no overflow when just full", 32'(overflow), 0);
        wr_one(0); idle(5);
        check("R3 overflow set", 32'(overflow), 1);
        idle(120);
        rd_n(16);
        rd_one(0);                              // dropped write must not appear
        idle(150);
        check("R3 overflow sticky", 32'(overflow), 1);
        check("R11 all frames seen", 32'(exp_frames.size()), 0);
        check("R1 all samples seen", 32'(exp_rd_q.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule